// File: doc/BRIEF.md
# Oversampling Serial Receiver with Flagged Receive Queue

This block recovers asynchronous serial characters from a single receive line. A free-running strobe, `tick16`, marks sixteen sample points per bit period. A framing state machine finds the falling edge of a start bit and confirms it half a bit later. It then gathers five to eight data bits, least significant first, samples an optional parity bit and checks one or two stop bits. Each finished character goes into a 64-entry queue together with three flags of its own: parity error, framing error and break.

A host drains the queue through a show-ahead read port. The head entry is always visible, and a one-cycle `rd_en` removes it. A sticky overrun flag records a character that arrived while the queue was full. A fill-level request goes high once the queue holds at least a selectable number of entries.

The framing state machine has seven states. `S_IDLE` waits for a low line on a tick. `S_START` counts to mid start bit. `S_DATA` gathers data bits. `S_PARITY` samples the parity bit. `S_STOP1` and `S_STOP2` check the stop bits. `S_BRKWAIT` holds after a break until the line goes high. The transitions are:
- IDLE→START on a tick with the line low.
- START→IDLE at the eighth tick if the line is high there (false start).
- START→DATA at that same tick if the line is still low.
- DATA→PARITY or DATA→STOP1 after the last data bit, depending on whether parity is enabled.
- PARITY→STOP1.
- STOP1→STOP2 when the line is high and two stop bits are selected.
- STOP1→BRKWAIT when the whole frame was zero.
- STOP1→IDLE in every other case.
- STOP2→IDLE.
- BRKWAIT→IDLE once the line is high.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, `rd_valid`, `overrun` and `trig_req` are all 0.
- R2: A start is accepted only if the line is still low on the eighth tick after the tick that first saw it low. Otherwise the receiver returns to idle and stores nothing.
- R3: Data bits are sampled 16 ticks apart, starting 16 ticks after the mid-start sample, least significant bit first. `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits above the word length read as 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 selects even parity and 0 selects odd parity. A mismatch sets that entry's `rd_perr`.
- R5: A stop bit sampled low sets that entry's `rd_ferr`. With `cfg_stop2`=1 and the first stop bit high, a second stop bit is also checked.
- R6: A frame whose data, parity and first stop bit are all low is stored as one entry: data 0x00, `rd_brk`=1, `rd_ferr`=1, `rd_perr`=0. Nothing more is stored until the line has been high.
- R7: The queue holds 64 entries in arrival order. Each entry keeps its own flags. The head is shown while `rd_valid`=1, and `rd_en` removes it.
- R8: A character that completes while 64 entries are held is discarded and the held entries are unchanged. `overrun` is then set and stays set until an `ovr_clr` pulse.
- R9: `cfg_trig` codes 0, 1, 2 and 3 select levels 8, 16, 56 and 60. `trig_req` is 1 exactly while the occupancy is at or above the selected level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_wlen | input | 2 | Word length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| cfg_stop2 | input | 1 | Check a second stop bit |
| cfg_trig | input | 2 | Fill-level request select |
| rd_en | input | 1 | Remove the head entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| overrun | output | 1 | Sticky overrun flag |
| trig_req | output | 1 | Fill level reached |

## Verification
A character is registered as a push on the clock edge of the tick that samples its last stop bit. It reaches the queue on the following edge, so `rd_valid`, the head fields and `trig_req` change two clocks after that tick; `overrun` changes on the same edge as the queue would have. A removal takes effect at the edge after `rd_en` is raised, and `trig_req` follows the occupancy combinationally. The bench drives the line for whole bit periods, so it samples results at least eight ticks past each last stop sample. Every sample is taken on the falling clock edge, which avoids any race with these updates.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2,
        S_BRKWAIT
    } rx_state_t;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/serial_rx_framer.sv
`timescale 1ns/1ps
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick16,
    input  logic      rxd,
    input  logic [1:0] cfg_wlen,
    input  logic      cfg_par_en,
    input  logic      cfg_par_even,
    input  logic      cfg_stop2,
    output logic      push,
    output rx_entry_t push_entry
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

    rx_state_t     state, state_nxt;
    logic [CW-1:0] cnt;
    logic [2:0]    bitidx;
    logic [7:0]    shreg;
    logic          par_bit;
    logic          bit_end;
    logic          last_data;
    logic          zero_frame;
    logic          perr_calc;

    assign bit_end    = tick16 && (cnt == BIT_LAST);
    assign last_data  = (bitidx == ({1'b0, cfg_wlen} + 3'd4));
    assign zero_frame = (shreg == 8'd0) && !par_bit;
    assign perr_calc  = cfg_par_en && ((^shreg ^ par_bit) == cfg_par_even);

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:    if (tick16 && !rxd) state_nxt = S_START;
            S_START:   if (tick16 && cnt == MID_LAST) state_nxt = rxd ? S_IDLE : S_DATA;
            S_DATA:    if (bit_end && last_data) state_nxt = cfg_par_en ? S_PARITY : S_STOP1;
            S_PARITY:  if (bit_end) state_nxt = S_STOP1;
            S_STOP1: begin
                if (bit_end) begin
                    if (!rxd && zero_frame)    state_nxt = S_BRKWAIT;
                    else if (rxd && cfg_stop2) state_nxt = S_STOP2;
                    else                       state_nxt = S_IDLE;
                end
            end
            S_STOP2:   if (bit_end) state_nxt = S_IDLE;
            S_BRKWAIT: if (rxd) state_nxt = S_IDLE;
            default:   state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            bitidx     <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            if (state == S_IDLE || state == S_BRKWAIT) begin
                cnt <= '0;
            end else if (tick16) begin
                cnt <= (state_nxt != state || cnt == BIT_LAST) ? '0 : cnt + 1'b1;
            end
            if (state == S_IDLE && state_nxt == S_START) begin
                shreg   <= '0;
                bitidx  <= '0;
                par_bit <= 1'b0;
            end
            if (state == S_DATA && bit_end) begin
                shreg[bitidx] <= rxd;
                bitidx        <= bitidx + 3'd1;
            end
            if (state == S_PARITY && bit_end) par_bit <= rxd;
            if (state == S_STOP1 && bit_end) begin
                if (!rxd && zero_frame) begin
                    push       <= 1'b1;
                    push_entry <= '{brk: 1'b1, ferr: 1'b1, perr: 1'b0, data: 8'd0};
                end else if (!rxd || !cfg_stop2) begin
                    push       <= 1'b1;
                    push_entry <= '{brk: 1'b0, ferr: !rxd, perr: perr_calc, data: shreg};
                end
            end
            if (state == S_STOP2 && bit_end) begin
                push       <= 1'b1;
                push_entry <= '{brk: 1'b0, ferr: !rxd, perr: perr_calc, data: shreg};
            end
        end
    end

    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && tick16 && cnt == MID_LAST && rxd) |=> (state == S_IDLE && !push)); // R2
    AST_DATA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((push_entry.data >> ({2'b00, cfg_wlen} + 4'd5)) == 8'd0)); // R3
    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> (push_entry.data == 8'd0 && push_entry.ferr && !push_entry.perr)); // R6
    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRKWAIT && !rxd) |=> !push); // R6

endmodule

// File: rtl/serial_rx_fifo.sv
`timescale 1ns/1ps
module serial_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    input  logic                       ovr_clr,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, do_wr, do_rd;

    assign full  = (count == FULL_CNT);
    assign do_wr = push && !full;
    assign do_rd = pop && (count != '0);
    assign head  = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            count <= count + (do_wr ? 1'b1 : 1'b0) - (do_rd ? 1'b1 : 1'b0);
            if (push && full) ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr); // R8
    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == FULL_CNT && $stable(rptr))); // R8

endmodule

// File: rtl/serial_rx_trigger.sv
`timescale 1ns/1ps
module serial_rx_trigger #(
    parameter int CW = 7,
    parameter int L0 = 8,
    parameter int L1 = 16,
    parameter int L2 = 56,
    parameter int L3 = 60
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    sel,
    output logic          req
);
    logic [CW-1:0] level;

    always_comb begin
        unique case (sel)
            2'd0:    level = CW'(L0);
            2'd1:    level = CW'(L1);
            2'd2:    level = CW'(L2);
            default: level = CW'(L3);
        endcase
        req = (count >= level);
    end

endmodule

// File: rtl/serial_rx_unit.sv
`timescale 1ns/1ps
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_stop2,
    input  logic [1:0] cfg_trig,
    input  logic       rd_en,
    input  logic       ovr_clr,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       overrun,
    output logic       trig_req
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int EW = $bits(rx_entry_t);

    logic          push;
    rx_entry_t     push_entry, head;
    logic [CW-1:0] count;

    serial_rx_framer #(.OSR(OSR)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
        .push(push), .push_entry(push_entry)
    );

    serial_rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_entry),
        .pop(rd_en), .ovr_clr(ovr_clr), .head(head), .count(count),
        .ovr(overrun)
    );

    serial_rx_trigger #(.CW(CW)) u_trig (
        .count(count), .sel(cfg_trig), .req(trig_req)
    );

    assign rd_valid = (count != '0);
    assign rd_data  = head.data;
    assign rd_perr  = head.perr;
    assign rd_ferr  = head.ferr;
    assign rd_brk   = head.brk;

    AST_TRIG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> trig_req); // R9
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !trig_req); // R9

endmodule

// File: tb/sim_serial_rx_unit.sv
`timescale 1ns/1ps
module sim_serial_rx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic [1:0] cfg_trig = 2'd0;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       rd_valid, rd_perr, rd_ferr, rd_brk, overrun, trig_req;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_rx_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_stop2(cfg_stop2), .cfg_trig(cfg_trig), .rd_en(rd_en), .ovr_clr(ovr_clr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .rd_brk(rd_brk), .overrun(overrun), .trig_req(trig_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick16 = 1'b1;
            @(negedge clk); tick16 = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        tk(16);
    endtask

    // pmode: 0 none, 1 correct parity, 2 wrong parity
    task automatic send_frame(input logic [7:0] d, input int nbits, input int pmode,
                              input logic s1, input logic s2);
        logic p;
        p = ^d;
        if (!cfg_par_even) p = ~p;
        if (pmode == 2) p = ~p;
        send_bit(1'b0);
        for (int i = 0; i < nbits; i++) send_bit(d[i]);
        if (pmode != 0) send_bit(p);
        send_bit(s1);
        if (cfg_stop2 && s1) send_bit(s2);
        rxd = 1'b1;
        tk(24);
    endtask

    task automatic pop_expect(input logic [7:0] d, input logic pe, input logic fe,
                              input logic bk, input string tag);
        @(negedge clk);
        chk(rd_valid == 1'b1, {tag, " valid"}, int'(rd_valid), 1);
        chk(rd_data == d, {tag, " data"}, int'(rd_data), int'(d));
        chk({rd_perr, rd_ferr, rd_brk} == {pe, fe, bk}, {tag, " flags"},
            int'({rd_perr, rd_ferr, rd_brk}), int'({pe, fe, bk}));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        chk(rd_valid == 1'b0, tag, int'(rd_valid), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        chk(trig_req == 1'b0, "R1 trig_req", int'(trig_req), 0);
    endtask

    task automatic t_wlen;
        cfg_wlen = 2'd3; send_frame(8'hA5, 8, 0, 1'b1, 1'b1);
        pop_expect(8'hA5, 1'b0, 1'b0, 1'b0, "R3 8bit");
        cfg_wlen = 2'd0; send_frame(8'h15, 5, 0, 1'b1, 1'b1);
        pop_expect(8'h15, 1'b0, 1'b0, 1'b0, "R3 5bit");
        cfg_wlen = 2'd1; send_frame(8'h2A, 6, 0, 1'b1, 1'b1);
        pop_expect(8'h2A, 1'b0, 1'b0, 1'b0, "R3 6bit");
        cfg_wlen = 2'd2; send_frame(8'h5B, 7, 0, 1'b1, 1'b1);
        pop_expect(8'h5B, 1'b0, 1'b0, 1'b0, "R3 7bit");
        expect_empty("R3 drained");
        cfg_wlen = 2'd3;
    endtask

    task automatic t_parity;
        cfg_par_en = 1'b1;
        cfg_par_even = 1'b1;
        send_frame(8'h3C, 8, 1, 1'b1, 1'b1);
        send_frame(8'h3D, 8, 2, 1'b1, 1'b1);
        cfg_par_even = 1'b0;
        send_frame(8'h07, 8, 1, 1'b1, 1'b1);
        send_frame(8'h80, 8, 2, 1'b1, 1'b1);
        pop_expect(8'h3C, 1'b0, 1'b0, 1'b0, "R4 even ok");
        pop_expect(8'h3D, 1'b1, 1'b0, 1'b0, "R4 even bad R7 order");
        pop_expect(8'h07, 1'b0, 1'b0, 1'b0, "R4 odd ok");
        pop_expect(8'h80, 1'b1, 1'b0, 1'b0, "R4 odd bad");
        cfg_par_en = 1'b0;
    endtask

    task automatic t_frame;
        send_frame(8'h81, 8, 0, 1'b0, 1'b1);
        pop_expect(8'h81, 1'b0, 1'b1, 1'b0, "R5 stop low");
        expect_empty("R5 no extra entry");
        cfg_stop2 = 1'b1;
        send_frame(8'h42, 8, 0, 1'b1, 1'b0);
        pop_expect(8'h42, 1'b0, 1'b1, 1'b0, "R5 second stop low");
        send_frame(8'h24, 8, 0, 1'b1, 1'b1);
        pop_expect(8'h24, 1'b0, 1'b0, 1'b0, "R5 two stops ok");
        cfg_stop2 = 1'b0;
    endtask

    task automatic t_false_start;
        rxd = 1'b0; tk(8);
        rxd = 1'b1; tk(24);
        expect_empty("R2 false start stored");
        send_frame(8'h5A, 8, 0, 1'b1, 1'b1);
        pop_expect(8'h5A, 1'b0, 1'b0, 1'b0, "R2 next frame");
        expect_empty("R2 single entry");
    endtask

    task automatic t_break;
        rxd = 1'b0; tk(16 * 14);
        rxd = 1'b1; tk(8);
        pop_expect(8'h00, 1'b0, 1'b1, 1'b1, "R6 break entry");
        expect_empty("R6 one entry only");
        send_frame(8'h33, 8, 0, 1'b1, 1'b1);
        pop_expect(8'h33, 1'b0, 1'b0, 1'b0, "R6 resume");
    endtask

    task automatic trig_at(input int k);
        int lv[4];
        lv = '{8, 16, 56, 60};
        for (int s = 0; s < 4; s++) begin
            cfg_trig = 2'(s);
            @(negedge clk);
            chk(trig_req == (k >= lv[s]), $sformatf("R9 level %0d fill %0d", lv[s], k),
                int'(trig_req), int'(k >= lv[s]));
        end
        cfg_trig = 2'd0;
    endtask

    task automatic t_fill;
        for (int k = 1; k <= 64; k++) begin
            send_frame(8'(k), 8, 0, 1'b1, 1'b1);
            if (k == 7 || k == 8 || k == 15 || k == 16 || k == 55 || k == 56 ||
                k == 59 || k == 60) trig_at(k);
        end
        chk(overrun == 1'b0, "R8 no overrun at 64", int'(overrun), 0);
        send_frame(8'hEE, 8, 0, 1'b1, 1'b1);
        chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
        for (int k = 1; k <= 64; k++)
            pop_expect(8'(k), 1'b0, 1'b0, 1'b0, $sformatf("R7 R8 entry %0d", k));
        expect_empty("R8 extra char discarded");
        trig_at(0);
        chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R8 overrun cleared", int'(overrun), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wlen();
        t_parity();
        t_frame();
        t_false_start();
        t_break();
        t_fill();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule